// File: doc/BRIEF.md
# Memory-Mapped Performance Counter Unit

This block counts activity on a shared cache or interconnect. It holds a bank of general event counters and one free-running cycle counter. All counters are 64 bits wide and software can load any of them. Each general counter has a select register that holds a 32-bit event code. A counter advances by one in each cycle in which the event input named by its code is high, but only while the global enable bit is set. The cycle counter needs no code and advances on every enabled clock.

When a counter wraps from all ones to zero, it sets its own bit in a sticky overflow status register. Software clears a status bit by writing a one to it. The single level interrupt is high whenever a status bit and its matching enable bit are both set. Software reaches every register through a plain 64-bit port: a write strobe, a byte address and write data. Read data is combinational from the address.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Registers sit at byte offsets whose low three bits are zero. The map is: control at 0x040 (bit 0 is the global enable, other bits read zero); overflow status at 0x048; interrupt enable at 0x050 (only bits 0..15 and bit 63 are stored, the rest read zero); cycle counter at 0x058; select for counter i at 0x060+8*i (only the low 32 bits are stored); event counter i at 0x160+8*i. Every counter can be written with any 64-bit value, and counting continues from the value written.
- R3: The cycle counter increments once per clock while the enable bit is 1, and holds while it is 0.
- R4: Event counter i increments by one in each cycle in which the enable bit is 1 and the `evt_in` bit chosen by its code is 1. The codes are: bit 0 = 0x04000701, bit 1 = 0x03000001, bit 2 = 0x00901202, bit 3 = 0x04008002, bit 4 = 0x00000403.
- R5: A counter whose select code is not one of the five codes (zero included) never counts, whatever the event inputs do.
- R6: A wrap from all ones to zero sets overflow status bit i for event counter i, and bit 63 for the cycle counter.
- R7: Writing a 1 to a status bit clears it. Writing a 0 leaves it as it is. Writes can never set a status bit. If a clear and a new overflow of the same bit fall in the same cycle, the bit ends up set.
- R8: `irq` is high exactly when some overflow status bit and the matching interrupt enable bit are both 1.
- R9: If a software write to a counter and an increment of that counter fall in the same cycle, the written value is stored and no overflow is recorded.
- R10: Reads of unmapped or unaligned offsets return zero. Writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| evt_in | input | 5 | Event pulses, one bit per event kind |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can collide in a single cycle. The first is a write-one-to-clear of a status bit arriving in the same cycle as a fresh wrap of that counter. The bench provokes it by preloading the counter to all ones and driving its event while it writes the clear, then reads back the status register. The second is a software load of a counter in the same cycle as an increment of that counter. The bench drives the selected event high during the write, then checks both the stored value and the absence of a new status bit. A behavioural model tracks every register on each clock, so both outcomes are judged against the stated priority: the set wins over the clear, and the write wins over the increment.

// File: rtl/pmu_cnt_pkg.sv
package pmu_cnt_pkg;
   localparam int REG_W          = 64;
   localparam int CODE_W         = 32;
   localparam int EVT_KINDS      = 5;
   localparam int CYC_STATUS_BIT = 63;

   localparam int OFS_CTRL   = 'h040;
   localparam int OFS_STATUS = 'h048;
   localparam int OFS_IE     = 'h050;
   localparam int OFS_CYCLE  = 'h058;
   localparam int OFS_SEL    = 'h060;
   localparam int OFS_CTR    = 'h160;

   // event code recognised on evt_in bit k
   function automatic logic [CODE_W-1:0] evt_code(input int k);
      case (k)
         0:       return 32'h0400_0701;
         1:       return 32'h0300_0001;
         2:       return 32'h0090_1202;
         3:       return 32'h0400_8002;
         4:       return 32'h0000_0403;
         default: return '0;
      endcase
   endfunction
endpackage

// File: rtl/pmu_event_match.sv
module pmu_event_match
   import pmu_cnt_pkg::*;
#(
   parameter int KINDS = EVT_KINDS
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic [KINDS-1:0]  evt_i,
   output logic              fire_o
);
   logic [KINDS-1:0] hit;

   if (KINDS < 1 || KINDS > EVT_KINDS) begin : g_bad_kinds
      $error("pmu_event_match: KINDS out of range");
   end

   for (genvar k = 0; k < KINDS; k++) begin : g_kind
      assign hit[k] = (code_i == evt_code(k)) && evt_i[k];
   end

   assign fire_o = |hit;

   // R4
   always_comb begin
      kind_unique_chk: assert ($onehot0(hit));
   end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         inc_i,
   output logic [W-1:0] count_o,
   output logic         wrap_o
);
   logic [W-1:0] q;

   if (W < 2) begin : g_bad_w
      $error("pmu_counter: W too small");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (load_i) q <= load_val_i;
      else if (inc_i)  q <= q + 1'b1;
   end

   assign count_o = q;
   assign wrap_o  = inc_i & ~load_i & (&q);

   // R9
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> count_o == $past(load_val_i));
   // R4
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i) |=> count_o == $past(count_o) + 1'b1);
   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !load_i) |=> $stable(count_o));
   // R6
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> count_o == '0);
endmodule

// File: rtl/pmu_ovf_status.sv
module pmu_ovf_status #(
   parameter int N = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] status_o
);
   logic [N-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_i) | set_i;
   end

   assign status_o = q;

   // R6
   set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> (status_o & $past(set_i)) == $past(set_i));
   // R7
   clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i != '0) |=> (status_o & $past(clr_i & ~set_i)) == '0);
   // R7
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0) |=> (status_o & ~$past(status_o)) == '0);
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
   import pmu_cnt_pkg::*;
#(
   parameter int NUM_CTR = 16,
   parameter int CW      = 64,
   parameter int AW      = 12,
   parameter int KINDS   = EVT_KINDS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [AW-1:0]    reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic [KINDS-1:0] evt_in,
   output logic             irq
);
   localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
   localparam logic [AW-1:0] A_CTRL   = AW'(OFS_CTRL);
   localparam logic [AW-1:0] A_STATUS = AW'(OFS_STATUS);
   localparam logic [AW-1:0] A_IE     = AW'(OFS_IE);
   localparam logic [AW-1:0] A_CYCLE  = AW'(OFS_CYCLE);
   localparam logic [AW-1:0] A_SEL_LO = AW'(OFS_SEL);
   localparam logic [AW-1:0] A_SEL_HI = AW'(OFS_SEL + 8 * NUM_CTR);
   localparam logic [AW-1:0] A_CTR_LO = AW'(OFS_CTR);
   localparam logic [AW-1:0] A_CTR_HI = AW'(OFS_CTR + 8 * NUM_CTR);
   localparam logic [REG_W-1:0] IE_MASK =
      (REG_W'(1) << CYC_STATUS_BIT) | ((REG_W'(1) << NUM_CTR) - REG_W'(1));

   if (NUM_CTR < 1 || NUM_CTR > 32) begin : g_bad_num
      $error("pmu_counter_unit: NUM_CTR must be 1..32");
   end
   if (CW < 8 || CW > REG_W) begin : g_bad_cw
      $error("pmu_counter_unit: CW must be 8..64");
   end
   if ((OFS_CTR + 8 * NUM_CTR) > (1 << AW)) begin : g_bad_aw
      $error("pmu_counter_unit: AW too narrow for the map");
   end

   // ---------------- decode ----------------
   logic             aligned, hit_ctrl, hit_st, hit_ie, hit_cyc, in_sel, in_ctr;
   logic [AW-1:0]    sel_off, ctr_off;
   logic [IDX_W-1:0] sel_idx, ctr_idx;

   assign aligned  = (reg_addr[2:0] == 3'b000);
   assign hit_ctrl = aligned && (reg_addr == A_CTRL);
   assign hit_st   = aligned && (reg_addr == A_STATUS);
   assign hit_ie   = aligned && (reg_addr == A_IE);
   assign hit_cyc  = aligned && (reg_addr == A_CYCLE);
   assign in_sel   = aligned && (reg_addr >= A_SEL_LO) && (reg_addr < A_SEL_HI);
   assign in_ctr   = aligned && (reg_addr >= A_CTR_LO) && (reg_addr < A_CTR_HI);
   assign sel_off  = reg_addr - A_SEL_LO;
   assign ctr_off  = reg_addr - A_CTR_LO;
   assign sel_idx  = sel_off[3 +: IDX_W];
   assign ctr_idx  = ctr_off[3 +: IDX_W];

   // ---------------- configuration registers ----------------
   logic              ctrl_en;
   logic [REG_W-1:0]  ie_q;
   logic [CODE_W-1:0] sel_q [NUM_CTR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_en <= 1'b0;
         ie_q    <= '0;
      end else begin
         if (reg_we && hit_ctrl) ctrl_en <= reg_wdata[0];
         if (reg_we && hit_ie)   ie_q    <= reg_wdata & IE_MASK;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_CTR; i++) begin
         if (!rst_n)
            sel_q[i] <= '0;
         else if (reg_we && in_sel && (sel_idx == IDX_W'(i)))
            sel_q[i] <= reg_wdata[CODE_W-1:0];
      end
   end

   // ---------------- event counters ----------------
   logic [CW-1:0]      ctr_val [NUM_CTR];
   logic [NUM_CTR-1:0] ctr_wrap;

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      logic fire, load;
      assign load = reg_we && in_ctr && (ctr_idx == IDX_W'(i));

      pmu_event_match #(.KINDS(KINDS)) u_match (
         .code_i (sel_q[i]),
         .evt_i  (evt_in),
         .fire_o (fire)
      );

      pmu_counter #(.W(CW)) u_cnt (
         .clk        (clk),
         .rst_n      (rst_n),
         .load_i     (load),
         .load_val_i (reg_wdata[CW-1:0]),
         .inc_i      (ctrl_en & fire),
         .count_o    (ctr_val[i]),
         .wrap_o     (ctr_wrap[i])
      );
   end

   // ---------------- cycle counter ----------------
   logic [CW-1:0] cyc_val;
   logic          cyc_wrap, cyc_load;

   assign cyc_load = reg_we && hit_cyc;

   pmu_counter #(.W(CW)) u_cyc (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (cyc_load),
      .load_val_i (reg_wdata[CW-1:0]),
      .inc_i      (ctrl_en),
      .count_o    (cyc_val),
      .wrap_o     (cyc_wrap)
   );

   // ---------------- overflow status ----------------
   logic [REG_W-1:0] set_v, clr_v, st_q;

   always_comb begin
      set_v = '0;
      for (int i = 0; i < NUM_CTR; i++) set_v[i] = ctr_wrap[i];
      set_v[CYC_STATUS_BIT] = cyc_wrap;
   end

   assign clr_v = (reg_we && hit_st) ? reg_wdata : '0;

   pmu_ovf_status #(.N(REG_W)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_v),
      .clr_i    (clr_v),
      .status_o (st_q)
   );

   assign irq = |(st_q & ie_q);

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      if (hit_ctrl)     reg_rdata[0] = ctrl_en;
      else if (hit_st)  reg_rdata = st_q;
      else if (hit_ie)  reg_rdata = ie_q;
      else if (hit_cyc) reg_rdata = REG_W'(cyc_val);
      else if (in_sel)  reg_rdata = REG_W'(sel_q[sel_idx]);
      else if (in_ctr)  reg_rdata = REG_W'(ctr_val[ctr_idx]);
   end

   // R3
   cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en && !cyc_load) |=> $stable(cyc_val));
   // R10
   unaligned_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !aligned) |=> ($stable(ctrl_en) && $stable(ie_q)));
   // R2
   ie_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (ie_q & ~IE_MASK) == '0);
endmodule

// File: tb/sim_pmu_counter_unit.sv
`timescale 1ns/1ps
module sim_pmu_counter_unit;
   localparam int N = 16;
   localparam logic [63:0] ONES = '1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [4:0]  evt_in = '0;
   logic        irq;

   always #5 clk = ~clk;

   pmu_counter_unit u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
   );

   // behavioural reference state
   logic [63:0] m_ctr [N];
   logic [31:0] m_sel [N];
   logic [63:0] m_cyc, m_st, m_ie;
   logic        m_en;
   int checks = 0, fails = 0;

   function automatic int code_kind(input logic [31:0] c);
      case (c)
         32'h0400_0701: return 0;
         32'h0300_0001: return 1;
         32'h0090_1202: return 2;
         32'h0400_8002: return 3;
         32'h0000_0403: return 4;
         default:       return -1;
      endcase
   endfunction

   function automatic logic [63:0] m_read(input logic [11:0] a);
      if (a[2:0] != 3'b000) return '0;
      if (a == 12'h040) return {63'b0, m_en};
      if (a == 12'h048) return m_st;
      if (a == 12'h050) return m_ie;
      if (a == 12'h058) return m_cyc;
      if (a >= 12'h060 && a < 12'h060 + 8 * N) return {32'b0, m_sel[int'((a - 12'h060) >> 3)]};
      if (a >= 12'h160 && a < 12'h160 + 8 * N) return m_ctr[int'((a - 12'h160) >> 3)];
      return '0;
   endfunction

   task automatic m_clock(input logic we, input logic [11:0] a, input logic [63:0] d, input logic [4:0] ev);
      logic [63:0] set, clr;
      logic ok;
      int k;
      set = '0;
      clr = '0;
      ok = we && (a[2:0] == 3'b000);
      for (int i = 0; i < N; i++) begin
         k = code_kind(m_sel[i]);
         if (ok && a == 12'h160 + 12'(8 * i)) m_ctr[i] = d;
         else if (m_en && k >= 0 && ev[k]) begin
            if (m_ctr[i] == ONES) set[i] = 1'b1;
            m_ctr[i] = m_ctr[i] + 64'd1;
         end
      end
      if (ok && a == 12'h058) m_cyc = d;
      else if (m_en) begin
         if (m_cyc == ONES) set[63] = 1'b1;
         m_cyc = m_cyc + 64'd1;
      end
      if (ok && a == 12'h040) m_en = d[0];
      if (ok && a == 12'h050) m_ie = d & 64'h8000_0000_0000_FFFF;
      if (ok && a == 12'h048) clr = d;
      for (int i = 0; i < N; i++)
         if (ok && a == 12'h060 + 12'(8 * i)) m_sel[i] = d[31:0];
      m_st = (m_st & ~clr) | set;
   endtask

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic we, input logic [11:0] a, input logic [63:0] d, input logic [4:0] ev, input string tag);
      reg_we = we; reg_addr = a; reg_wdata = d; evt_in = ev;
      #1;
      chk(tag, "rdata", reg_rdata, m_read(a));
      chk(tag, "irq", {63'b0, irq}, {63'b0, |(m_st & m_ie)});
      @(posedge clk);
      m_clock(we, a, d, ev);
      @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] d, input string tag);
      step(1'b1, a, d, 5'b0, tag);
   endtask

   task automatic rd(input logic [11:0] a, input string tag);
      step(1'b0, a, '0, 5'b0, tag);
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_ctr[i] = '0; m_sel[i] = '0; end
      m_cyc = '0; m_st = '0; m_ie = '0; m_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(12'h040, "R1"); rd(12'h048, "R1"); rd(12'h050, "R1"); rd(12'h058, "R1");
      rd(12'h060, "R1"); rd(12'h160, "R1"); rd(12'h1D8, "R1");
      // R2 configuration and readback
      wr(12'h060, 64'h0400_0701, "R2");
      wr(12'h068, 64'h0300_0001, "R2");
      wr(12'h070, 64'h0090_1202, "R2");
      wr(12'h078, 64'h0400_8002, "R2");
      wr(12'h080, 64'h0000_0403, "R2");
      wr(12'h088, 64'h1234_5678, "R5");
      wr(12'h098, 64'hFFFF_FFFF_0400_0701, "R2");
      rd(12'h098, "R2");
      wr(12'h050, ONES, "R2");
      rd(12'h050, "R2");
      wr(12'h040, 64'h3, "R2");
      rd(12'h040, "R2");
      // R4 counting under varied patterns
      for (int c = 0; c < 48; c++)
         step(1'b0, 12'h160 + 12'(8 * (c % 8)), '0, 5'((c * 7) ^ (c >> 1)), "R4");
      // R5 unknown and zero codes
      for (int c = 0; c < 6; c++) step(1'b0, 12'h188, '0, 5'h1F, "R5");
      rd(12'h190, "R5");
      // R3 cycle counter run and hold
      rd(12'h058, "R3");
      wr(12'h040, 64'h0, "R3");
      for (int c = 0; c < 5; c++) step(1'b0, 12'h058, '0, 5'h1F, "R3");
      rd(12'h160, "R3");
      wr(12'h040, 64'h1, "R3");
      // R6 and R8 event wrap
      wr(12'h160, ONES - 64'd1, "R2");
      step(1'b0, 12'h048, '0, 5'h01, "R6");
      step(1'b0, 12'h048, '0, 5'h01, "R6");
      rd(12'h048, "R6");
      rd(12'h160, "R6");
      wr(12'h050, 64'h0, "R8");
      rd(12'h048, "R8");
      wr(12'h050, 64'h1, "R8");
      rd(12'h048, "R8");
      // R7 write-one-to-clear
      wr(12'h048, 64'h0, "R7");
      rd(12'h048, "R7");
      wr(12'h048, 64'h1, "R7");
      rd(12'h048, "R7");
      wr(12'h168, ONES, "R7");
      step(1'b0, 12'h048, '0, 5'h02, "R7");
      wr(12'h168, ONES, "R7");
      step(1'b1, 12'h048, 64'h2, 5'h02, "R7");
      rd(12'h048, "R7");
      wr(12'h048, ONES, "R7");
      rd(12'h048, "R7");
      // R6 and R8 cycle counter wrap
      wr(12'h050, 64'h8000_0000_0000_0000, "R8");
      wr(12'h058, ONES - 64'd2, "R6");
      for (int c = 0; c < 4; c++) step(1'b0, 12'h048, '0, 5'h0, "R6");
      rd(12'h058, "R6");
      // R9 write beats increment
      step(1'b1, 12'h170, 64'h55, 5'h04, "R9");
      rd(12'h170, "R9");
      step(1'b1, 12'h178, ONES, 5'h08, "R9");
      rd(12'h178, "R9");
      rd(12'h048, "R9");
      // R10 unmapped and unaligned
      wr(12'h100, 64'hDEAD, "R10");
      rd(12'h100, "R10");
      rd(12'h008, "R10");
      wr(12'h041, 64'h0, "R10");
      rd(12'h040, "R10");
      rd(12'h041, "R10");
      wr(12'h051, ONES, "R10");
      rd(12'h050, "R10");
      rd(12'h0E0, "R10");
      rd(12'h1E0, "R10");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule